// File: doc/BRIEF.md
# Three-Level DMA Address Sequencer

This block is the address and count engine of a single DMA channel. A transfer is described as a block of frames, each frame a row of arrays, and each array a run of bytes. Software loads a parameter set (source and destination start addresses, array length in bytes, arrays per frame, a reload value for later frames, frames per block, and separate signed strides for stepping between arrays and between frames on each side), together with a bit that selects the synchronisation granularity. After that, every trigger makes the sequencer issue address requests: one array per trigger in array-synchronised mode, or a whole frame of arrays in back-to-back cycles in frame-synchronised mode.

Triggers come from a peripheral event line or from a manual software line. The two lines are treated the same way, so a memory-to-memory transfer can run without any peripheral. Each request carries a source address, a destination address and a byte count. A one-cycle completion pulse is raised with the last array of the block. When a side is a fixed peripheral register, its strides are programmed as zero. The data movement itself, arbitration between channels and the chaining of parameter sets are done by other blocks.

Top module: `dma3d_addr_seq`

## Requirements
- R1: While reset is asserted, req_valid, done, missed and busy are all low. Reset selects array-synchronised mode.
- R2: In array-synchronised mode (cfg_frame_sync=0 at load), each accepted trigger produces exactly one request, in the cycle after the trigger, with req_cnt equal to the loaded array length.
- R3: In array-synchronised mode, consecutive arrays of one frame are one array stride apart. The first frame holds cfg_bcnt arrays and every later frame holds cfg_brld arrays.
- R4: In array-synchronised mode, the first array of the next frame lies at the address of the last array of the previous frame plus the frame stride.
- R5: In frame-synchronised mode (cfg_frame_sync=1 at load), each accepted trigger produces cfg_bcnt requests in consecutive cycles, starting in the cycle after the trigger, each with req_cnt equal to the array length. Every frame holds cfg_bcnt arrays and cfg_brld has no effect.
- R6: In frame-synchronised mode, the first array of the next frame lies at the first array of the previous frame plus the frame stride.
- R7: Strides are 16-bit two's-complement values, sign-extended and added modulo 2^32 to 32-bit byte addresses. A zero stride holds the address fixed.
- R8: done is high in exactly the cycle of the block's final request and in no other cycle. busy is high from the cycle after a load with non-zero counts until the final request, and is low in the cycle done is high.
- R9: A pulse on sw_evt acts exactly as a pulse on sync_evt. Pulses on both lines in the same cycle count as one trigger.
- R10: A trigger that arrives when no block is pending (never loaded or already complete), or while a frame burst is still being issued, raises missed for one cycle in the next cycle, issues no request, and leaves the sequence unchanged.
- R11: The synchronisation mode is captured at load. A later change of cfg_frame_sync does not alter the running block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture the parameter set and start a block |
| cfg_src | input | 32 | Source start byte address |
| cfg_dst | input | 32 | Destination start byte address |
| cfg_acnt | input | 16 | Bytes per array |
| cfg_bcnt | input | 16 | Arrays in the first frame (all frames in frame mode) |
| cfg_brld | input | 16 | Arrays in later frames, array mode only |
| cfg_ccnt | input | 16 | Frames per block |
| cfg_src_bidx | input | 16 | Signed source stride between arrays |
| cfg_dst_bidx | input | 16 | Signed destination stride between arrays |
| cfg_src_cidx | input | 16 | Signed source stride between frames |
| cfg_dst_cidx | input | 16 | Signed destination stride between frames |
| cfg_frame_sync | input | 1 | 0 array-synchronised, 1 frame-synchronised |
| sync_evt | input | 1 | Peripheral trigger pulse |
| sw_evt | input | 1 | Manual trigger pulse |
| req_valid | output | 1 | A request is presented this cycle |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_cnt | output | 16 | Byte count of the array |
| busy | output | 1 | A block is loaded and not yet complete |
| done | output | 1 | One-cycle completion pulse with the final request |
| missed | output | 1 | One-cycle pulse for a rejected trigger |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the peripheral trigger and the manual trigger. The second pair is a new trigger and the continuing beats of a frame burst. The bench raises both trigger lines in one cycle and checks through the scoreboard that exactly one array is issued. In frame mode it sends a second trigger in the cycle right after a burst starts, and expects missed together with an unchanged run of burst addresses. The completion pulse falls in the same cycle as the final request. Its position is judged by comparing every request against a queue of expected addresses and last flags built from the requirements.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

  typedef enum logic {
    SYNC_ARRAY = 1'b0,
    SYNC_FRAME = 1'b1
  } sync_mode_e;

endpackage

// File: rtl/dma3d_evt_gate.sv
module dma3d_evt_gate (
  input  logic sync_evt_i,
  input  logic sw_evt_i,
  input  logic load_i,
  input  logic active_i,
  input  logic burst_i,
  output logic accept_o,
  output logic reject_o
);

  logic trig;
  logic ready;

  always_comb begin
    trig     = sync_evt_i | sw_evt_i;
    ready    = active_i & ~burst_i;
    accept_o = trig & ready & ~load_i;
    reject_o = trig & ~ready & ~load_i;
  end

endmodule

// File: rtl/dma3d_cnt.sv
module dma3d_cnt
  import dma3d_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] bcnt_i,
  input  logic [CW-1:0] brld_i,
  input  logic [CW-1:0] ccnt_i,
  input  sync_mode_e    mode_i,
  input  logic          step_i,
  output logic          frame_end_o,
  output logic          block_end_o,
  output logic          active_o,
  output logic          burst_o
);

  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  logic [CW-1:0] bfix_q, bfix_d;
  logic [CW-1:0] brld_q, brld_d;
  logic [CW-1:0] blive_q, blive_d;
  logic [CW-1:0] beat_q, beat_d;
  logic [CW-1:0] c_q, c_d;
  logic [CW-1:0] rem;

  always_comb begin
    rem         = (beat_q == ZERO) ? bfix_q : beat_q;
    frame_end_o = (mode_i == SYNC_FRAME) ? (rem <= ONE) : (blive_q <= ONE);
    block_end_o = frame_end_o & (c_q == ONE);
    active_o    = (c_q != ZERO);
    burst_o     = (beat_q != ZERO);
  end

  always_comb begin
    bfix_d  = bfix_q;
    brld_d  = brld_q;
    blive_d = blive_q;
    beat_d  = beat_q;
    c_d     = c_q;
    if (load_i) begin
      bfix_d  = bcnt_i;
      brld_d  = brld_i;
      blive_d = bcnt_i;
      beat_d  = ZERO;
      c_d     = (bcnt_i == ZERO) ? ZERO : ccnt_i;
    end else if (step_i) begin
      if (mode_i == SYNC_FRAME) begin
        beat_d = frame_end_o ? ZERO : (rem - ONE);
      end else begin
        blive_d = frame_end_o ? brld_q : (blive_q - ONE);
      end
      if (frame_end_o) begin
        c_d = c_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bfix_q  <= ZERO;
      brld_q  <= ZERO;
      blive_q <= ZERO;
      beat_q  <= ZERO;
      c_q     <= ZERO;
    end else if (load_i || step_i) begin
      bfix_q  <= bfix_d;
      brld_q  <= brld_d;
      blive_q <= blive_d;
      beat_q  <= beat_d;
      c_q     <= c_d;
    end
  end

endmodule

// File: rtl/dma3d_addr_walk.sv
module dma3d_addr_walk
  import dma3d_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] bidx_i,
  input  logic [IW-1:0] cidx_i,
  input  sync_mode_e    mode_i,
  input  logic          step_i,
  input  logic          frame_end_i,
  output logic [AW-1:0] addr_o
);

  localparam int unsigned EXT = AW - IW;

  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] frm_q, frm_d;
  logic [IW-1:0] bidx_q, cidx_q;
  logic [AW-1:0] bstep, cstep;

  always_comb begin
    bstep = {{EXT{bidx_q[IW-1]}}, bidx_q};
    cstep = {{EXT{cidx_q[IW-1]}}, cidx_q};
  end

  always_comb begin
    cur_d = cur_q;
    frm_d = frm_q;
    if (load_i) begin
      cur_d = base_i;
      frm_d = base_i;
    end else if (step_i) begin
      if (!frame_end_i) begin
        cur_d = cur_q + bstep;
      end else if (mode_i == SYNC_FRAME) begin
        cur_d = frm_q + cstep;
        frm_d = frm_q + cstep;
      end else begin
        cur_d = cur_q + cstep;
        frm_d = cur_q + cstep;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidx_q <= '0;
      cidx_q <= '0;
    end else if (load_i) begin
      bidx_q <= bidx_i;
      cidx_q <= cidx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      frm_q <= '0;
    end else if (load_i || step_i) begin
      cur_q <= cur_d;
      frm_q <= frm_d;
    end
  end

  assign addr_o = cur_q;

endmodule

// File: rtl/dma3d_addr_seq.sv
module dma3d_addr_seq
  import dma3d_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter int unsigned IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_acnt,
  input  logic [CW-1:0] cfg_bcnt,
  input  logic [CW-1:0] cfg_brld,
  input  logic [CW-1:0] cfg_ccnt,
  input  logic [IW-1:0] cfg_src_bidx,
  input  logic [IW-1:0] cfg_dst_bidx,
  input  logic [IW-1:0] cfg_src_cidx,
  input  logic [IW-1:0] cfg_dst_cidx,
  input  logic          cfg_frame_sync,
  input  logic          sync_evt,
  input  logic          sw_evt,
  output logic          req_valid,
  output logic [AW-1:0] req_src,
  output logic [AW-1:0] req_dst,
  output logic [CW-1:0] req_cnt,
  output logic          busy,
  output logic          done,
  output logic          missed
);

  localparam int unsigned NSIDE = 2;

  sync_mode_e    mode_q;
  logic [CW-1:0] acnt_q;
  logic          frame_end, block_end, active, burst;
  logic          accept, reject, step;
  logic [AW-1:0] base   [NSIDE];
  logic [IW-1:0] bidx   [NSIDE];
  logic [IW-1:0] cidx   [NSIDE];
  logic [AW-1:0] cur    [NSIDE];

  always_comb begin
    base[0] = cfg_src;      base[1] = cfg_dst;
    bidx[0] = cfg_src_bidx; bidx[1] = cfg_dst_bidx;
    cidx[0] = cfg_src_cidx; cidx[1] = cfg_dst_cidx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SYNC_ARRAY;
      acnt_q <= '0;
    end else if (cfg_load) begin
      mode_q <= cfg_frame_sync ? SYNC_FRAME : SYNC_ARRAY;
      acnt_q <= cfg_acnt;
    end
  end

  dma3d_evt_gate u_gate (
    .sync_evt_i (sync_evt),
    .sw_evt_i   (sw_evt),
    .load_i     (cfg_load),
    .active_i   (active),
    .burst_i    (burst),
    .accept_o   (accept),
    .reject_o   (reject)
  );

  always_comb begin
    step = ~cfg_load & active & (burst | accept);
  end

  dma3d_cnt #(.CW(CW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (cfg_load),
    .bcnt_i      (cfg_bcnt),
    .brld_i      (cfg_brld),
    .ccnt_i      (cfg_ccnt),
    .mode_i      (mode_q),
    .step_i      (step),
    .frame_end_o (frame_end),
    .block_end_o (block_end),
    .active_o    (active),
    .burst_o     (burst)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma3d_addr_walk #(.AW(AW), .IW(IW)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (cfg_load),
      .base_i      (base[g]),
      .bidx_i      (bidx[g]),
      .cidx_i      (cidx[g]),
      .mode_i      (mode_q),
      .step_i      (step),
      .frame_end_i (frame_end),
      .addr_o      (cur[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      done      <= 1'b0;
      missed    <= 1'b0;
    end else begin
      req_valid <= step;
      done      <= step & block_end;
      missed    <= reject;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_src <= '0;
      req_dst <= '0;
      req_cnt <= '0;
    end else if (step) begin
      req_src <= cur[0];
      req_dst <= cur[1];
      req_cnt <= acnt_q;
    end
  end

  assign busy = active;

endmodule

// File: rtl/dma3d_addr_seq_chk.sv
module dma3d_addr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_load,
  input logic sync_evt,
  input logic sw_evt,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic missed
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_idle_in_reset_R1: assert (!req_valid && !done && !missed && !busy)
        else $error("outputs active during reset");
    end
  end

  assert_done_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_valid);

  assert_done_drops_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_idle_event_missed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sync_evt || sw_evt) && !busy && !cfg_load) |=> missed);

  assert_no_req_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_load) |=> !req_valid);

  assert_event_answered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sync_evt || sw_evt) && !cfg_load) |=> (req_valid || missed));

endmodule

bind dma3d_addr_seq dma3d_addr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_load  (cfg_load),
  .sync_evt  (sync_evt),
  .sw_evt    (sw_evt),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .missed    (missed)
);

// File: tb/dma3d_addr_seq_tb.sv
module dma3d_addr_seq_tb;

  typedef struct packed {
    logic [31:0] s;
    logic [31:0] d;
    logic [15:0] n;
    logic        last;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        cfg_load;
  logic [31:0] cfg_src, cfg_dst;
  logic [15:0] cfg_acnt, cfg_bcnt, cfg_brld, cfg_ccnt;
  logic [15:0] cfg_src_bidx, cfg_dst_bidx, cfg_src_cidx, cfg_dst_cidx;
  logic        cfg_frame_sync;
  logic        sync_evt, sw_evt;
  logic        req_valid, busy, done, missed;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_cnt;

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R2";
  exp_t  exp_q[$];

  dma3d_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_acnt(cfg_acnt),
    .cfg_bcnt(cfg_bcnt), .cfg_brld(cfg_brld), .cfg_ccnt(cfg_ccnt),
    .cfg_src_bidx(cfg_src_bidx), .cfg_dst_bidx(cfg_dst_bidx),
    .cfg_src_cidx(cfg_src_cidx), .cfg_dst_cidx(cfg_dst_cidx),
    .cfg_frame_sync(cfg_frame_sync), .sync_evt(sync_evt), .sw_evt(sw_evt),
    .req_valid(req_valid), .req_src(req_src), .req_dst(req_dst),
    .req_cnt(req_cnt), .busy(busy), .done(done), .missed(missed)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // Scoreboard monitor: compare each request against the expected queue
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, {cur_req, " unexpected request"}, {32'h0, req_src}, 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(req_src == e.s, {cur_req, " src"}, {32'h0, req_src}, {32'h0, e.s});
        chk(req_dst == e.d, {cur_req, " dst"}, {32'h0, req_dst}, {32'h0, e.d});
        chk(req_cnt == e.n, {cur_req, " cnt"}, {48'h0, req_cnt}, {48'h0, e.n});
        chk(done == e.last, "R8 done with final request", {63'h0, done}, {63'h0, e.last});
      end
    end else if (rst_n && done) begin
      chk(1'b0, "R8 done without request", 64'h1, 64'h0);
    end
  end

  // Driver: program the channel and push the expected requests
  task automatic load_cfg(input bit mode, input logic [31:0] s, input logic [31:0] d,
                          input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
                          input logic [15:0] c, input logic [15:0] sbi, input logic [15:0] dbi,
                          input logic [15:0] sci, input logic [15:0] dci);
    logic [31:0] ps, pd, fs, fd;
    int nb;
    cfg_frame_sync = mode; cfg_src = s; cfg_dst = d; cfg_acnt = a;
    cfg_bcnt = b; cfg_brld = r; cfg_ccnt = c;
    cfg_src_bidx = sbi; cfg_dst_bidx = dbi; cfg_src_cidx = sci; cfg_dst_cidx = dci;
    cfg_load = 1'b1;
    ps = s; pd = d;
    for (int f = 0; f < int'(c); f++) begin
      nb = (mode || f == 0) ? int'(b) : int'(r);
      fs = ps; fd = pd;
      for (int j = 0; j < nb; j++) begin
        exp_q.push_back('{s: ps, d: pd, n: a, last: (f == int'(c) - 1) && (j == nb - 1)});
        if (j < nb - 1) begin
          ps = ps + sx(sbi); pd = pd + sx(dbi);
        end
      end
      if (mode) begin
        ps = fs + sx(sci); pd = fd + sx(dci);
      end else begin
        ps = ps + sx(sci); pd = pd + sx(dci);
      end
    end
    @(negedge clk);
    cfg_load = 1'b0;
    chk(busy == 1'b1, "R8 busy after load", {63'h0, busy}, 64'h1);
  endtask

  task automatic fire(input bit hw, input bit sw, output bit m);
    sync_evt = hw; sw_evt = sw;
    @(negedge clk);
    sync_evt = 1'b0; sw_evt = 1'b0;
    m = missed;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, {req, " all expected requests issued"}, 64'(exp_q.size()), 64'h0);
    chk(busy == 1'b0, "R8 busy low after block", {63'h0, busy}, 64'h0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    bit m;
    rst_n = 1'b0; cfg_load = 1'b0; sync_evt = 1'b0; sw_evt = 1'b0;
    cfg_src = '0; cfg_dst = '0; cfg_acnt = '0; cfg_bcnt = '0; cfg_brld = '0; cfg_ccnt = '0;
    cfg_src_bidx = '0; cfg_dst_bidx = '0; cfg_src_cidx = '0; cfg_dst_cidx = '0;
    cfg_frame_sync = 1'b0;
    idle(3);
    // R1: quiet outputs in reset
    chk(!req_valid && !done && !missed && !busy, "R1 reset state",
        {60'h0, req_valid, done, missed, busy}, 64'h0);
    rst_n = 1'b1;
    idle(2);

    // R10: trigger with nothing loaded
    cur_req = "R10";
    fire(1'b1, 1'b0, m);
    chk(m == 1'b1, "R10 missed before any load", {63'h0, m}, 64'h1);
    idle(1);

    // R2 R3 R4 R9: array mode, port destination, mixed trigger lines
    cur_req = "R3/R4";
    load_cfg(1'b0, 32'h0000_1000, 32'h4000_0000, 16'd4, 16'd3, 16'd2, 16'd3,
             16'd4, 16'd0, 16'd8, 16'd0);
    for (int k = 0; k < 7; k++) begin
      fire(k % 3 != 1, k % 3 != 0, m);
      chk(m == 1'b0, "R9 trigger accepted on either line", {63'h0, m}, 64'h0);
      idle(k % 2);
    end
    idle(2);
    drained("R2");

    // R7: negative strides, wraparound, back-to-back triggers
    cur_req = "R7";
    load_cfg(1'b0, 32'h0000_0010, 32'hFFFF_FFF8, 16'd2, 16'd2, 16'd2, 16'd2,
             16'hFFFC, 16'h0004, 16'h8000, 16'h0010);
    for (int k = 0; k < 4; k++) begin
      fire(1'b0, 1'b1, m);
    end
    idle(2);
    drained("R7");

    // R5 R6 R11: frame mode, reload ignored, mode input changed after load
    cur_req = "R5/R6";
    load_cfg(1'b1, 32'h0002_0000, 32'h0003_0000, 16'd8, 16'd4, 16'd1, 16'd3,
             16'd8, 16'd16, 16'h0040, 16'hFFF0);
    cfg_frame_sync = 1'b0;
    for (int k = 0; k < 3; k++) begin
      fire(1'b1, 1'b0, m);
      chk(m == 1'b0, "R5 frame trigger accepted", {63'h0, m}, 64'h0);
      // R10: second trigger while the burst is still running
      fire(1'b0, 1'b1, m);
      chk(m == 1'b1, "R10 missed during burst", {63'h0, m}, 64'h1);
      idle(4);
    end
    idle(1);
    drained("R11");

    // R10: trigger after completion
    cur_req = "R10";
    fire(1'b1, 1'b1, m);
    chk(m == 1'b1, "R10 missed after completion", {63'h0, m}, 64'h1);
    idle(3);
    chk(exp_q.size() == 0, "R10 no request after completion", 64'(exp_q.size()), 64'h0);

    finish_run();
  end

endmodule